// File: doc/BRIEF.md
# Per-Channel Fault Protection Controller

This block sits between the fault detectors and the output driver control of an eight-channel switch array. Every channel has two synchronous detect inputs, one for overload and one for overtemperature. Each detect input passes through its own duration filter. A fault that outlasts the filter window is written into a 2-bit per-channel diagnosis code and pulls an active-low general fault flag low.

Each channel has two mode bits. The overload bit selects between current limiting only, where the channel stays enabled, and a latched shutdown. The overtemperature bit selects between automatic restart once the detector clears and a latched shutdown. The block drives a per-channel enable mask to the output control logic. A one-cycle diagnosis-read strobe clears the latched codes and the latched shutdowns, and so does the active-low reset. A fault that is still qualified during the strobe is recorded and latched again at once.

Top module: `fault_guard`

## Requirements
- R1: After reset every diagnosis code is 00, `fault_n` is 1 and every `ch_enable` bit is 1.
- R2: A detect input that is high for fewer than FILT_CYC consecutive clock samples and then drops has no effect. The diagnosis code, `fault_n` and `ch_enable` stay unchanged.
- R3: A detect input that is high for FILT_CYC consecutive samples is recorded at the clock edge that takes the last of those samples. Channel i's code is held in `diag_code[2i+1:2i]`: 01 means overload and 10 means overtemperature. `fault_n` goes low in the same cycle.
- R4: If a channel's `ovl_latch_mode` bit is 0, a qualified overload is recorded but that channel's `ch_enable` bit stays 1.
- R5: If a channel's `ovl_latch_mode` bit is 1, a qualified overload drives that channel's `ch_enable` bit to 0 from the recording edge. The bit stays 0 after the detect input drops and returns to 1 only through a clear.
- R6: If a channel's `ovt_latch_mode` bit is 0, a qualified overtemperature drives `ch_enable` to 0 from the recording edge. The bit returns to 1 at the first clock edge that samples the detect input low. The diagnosis code stays at 10.
- R7: If a channel's `ovt_latch_mode` bit is 1, a qualified overtemperature drives `ch_enable` to 0 until a clear, even after the detect input drops.
- R8: A newly qualified fault overwrites the channel's earlier code. When both faults are qualified in the same cycle, the code is 10.
- R9: A one-cycle `diag_clr` pulse sets every code to 00 and releases every latched shutdown, and `fault_n` then returns to 1. A fault that is still qualified during the pulse keeps its code and its latched shutdown.
- R10: A fault on one channel changes neither the code nor the enable bit of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovl_det | input | NUM_CH | Overload detect, one bit per channel |
| ovt_det | input | NUM_CH | Overtemperature detect, one bit per channel |
| ovl_latch_mode | input | NUM_CH | 1 = latched shutdown on overload, 0 = limit only |
| ovt_latch_mode | input | NUM_CH | 1 = latched shutdown on overtemperature, 0 = auto-restart |
| diag_clr | input | 1 | Diagnosis-read strobe, clears codes and latches |
| diag_code | output | 2*NUM_CH | Per-channel diagnosis code, 2 bits per channel |
| fault_n | output | 1 | General fault flag, low while any code is non-zero |
| ch_enable | output | NUM_CH | Per-channel enable mask to output control |

## Verification
Detect pulses one sample shorter than the window and pulses exactly as long as the window separate a filter that counts correctly from one that is off by one. The same qualified fault is applied to channels with different mode bits, so limit-only, latched and auto-restart behaviour are told apart from the enable mask, both while the detector is high and after it drops. Overload followed by overtemperature on one channel checks that a new code overwrites the old one. Both faults together check that overtemperature takes priority. A clear applied while a fault persists, and a fault on one channel viewed from the others, show whether clearing re-latches correctly and whether channels stay independent.

// File: rtl/fg_pkg.sv
package fg_pkg;
   typedef enum logic [1:0] {
      DIAG_NONE = 2'b00,
      DIAG_OVL  = 2'b01,
      DIAG_OVT  = 2'b10,
      DIAG_RSV  = 2'b11
   } diag_e;
endpackage

// File: rtl/fg_filter.sv
// Duration filter: qual is high while det has been high for FILT_CYC samples
module fg_filter #(
   parameter int FILT_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic det,
   output logic qual
);
   localparam int LIM   = FILT_CYC - 1;
   localparam int CNT_W = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;

   logic [CNT_W-1:0] cnt;
   logic             at_lim;

   assign at_lim = (cnt == CNT_W'(LIM));

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (!det)
         cnt <= '0;
      else if (!at_lim)
         cnt <= cnt + 1'b1;
   end

   assign qual = det & at_lim;
endmodule

// File: rtl/fg_channel.sv
// One channel: two filters, mode-dependent shutdown, diagnosis code
module fg_channel
   import fg_pkg::*;
#(
   parameter int FILT_CYC = 64
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ovl_det,
   input  logic  ovt_det,
   input  logic  ovl_latch,
   input  logic  ovt_latch,
   input  logic  clr,
   output diag_e code,
   output logic  en
);
   logic ovl_q, ovt_q;
   logic ovl_lock, ovt_lock, hot;

   fg_filter #(.FILT_CYC(FILT_CYC)) u_ovl_flt (
      .clk(clk), .rst_n(rst_n), .det(ovl_det), .qual(ovl_q)
   );
   fg_filter #(.FILT_CYC(FILT_CYC)) u_ovt_flt (
      .clk(clk), .rst_n(rst_n), .det(ovt_det), .qual(ovt_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code     <= DIAG_NONE;
         ovl_lock <= 1'b0;
         ovt_lock <= 1'b0;
         hot      <= 1'b0;
      end else begin
         if (ovt_q)
            code <= DIAG_OVT;
         else if (ovl_q)
            code <= DIAG_OVL;
         else if (clr)
            code <= DIAG_NONE;
         ovl_lock <= (ovl_q & ovl_latch) | (ovl_lock & ~clr);
         ovt_lock <= (ovt_q & ovt_latch) | (ovt_lock & ~clr);
         hot      <= ovt_q & ~ovt_latch;
      end
   end

   assign en = ~(ovl_lock | ovt_lock | hot);
endmodule

// File: rtl/fg_flag.sv
// General fault flag: low while any channel holds a code
module fg_flag #(
   parameter int NUM_CH = 8
) (
   input  logic [2*NUM_CH-1:0] codes,
   output logic                flag_n
);
   assign flag_n = ~(|codes);
endmodule

// File: rtl/fault_guard.sv
module fault_guard
   import fg_pkg::*;
#(
   parameter int NUM_CH   = 8,
   parameter int FILT_CYC = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CH-1:0]   ovl_det,
   input  logic [NUM_CH-1:0]   ovt_det,
   input  logic [NUM_CH-1:0]   ovl_latch_mode,
   input  logic [NUM_CH-1:0]   ovt_latch_mode,
   input  logic                diag_clr,
   output logic [2*NUM_CH-1:0] diag_code,
   output logic                fault_n,
   output logic [NUM_CH-1:0]   ch_enable
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("fault_guard: NUM_CH must be at least 1");
   end
   if (FILT_CYC < 1) begin : g_bad_filt
      $error("fault_guard: FILT_CYC must be at least 1");
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      diag_e code_i;
      fg_channel #(.FILT_CYC(FILT_CYC)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .ovl_det(ovl_det[i]), .ovt_det(ovt_det[i]),
         .ovl_latch(ovl_latch_mode[i]), .ovt_latch(ovt_latch_mode[i]),
         .clr(diag_clr), .code(code_i), .en(ch_enable[i])
      );
      assign diag_code[2*i +: 2] = code_i;
   end

   fg_flag #(.NUM_CH(NUM_CH)) u_flag (
      .codes(diag_code), .flag_n(fault_n)
   );
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
   parameter int NUM_CH = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_CH-1:0]   ovl_det,
   input logic [NUM_CH-1:0]   ovt_det,
   input logic                diag_clr,
   input logic [2*NUM_CH-1:0] diag_code,
   input logic                fault_n,
   input logic [NUM_CH-1:0]   ch_enable
);
   // R9: a clear with no detect active leaves everything clear
   p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (diag_clr && ovl_det == '0 && ovt_det == '0) |=> (diag_code == '0 && fault_n));

   // R3: the flag only falls after a detect input was active
   p_flag_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_n) |-> $past((|ovl_det) || (|ovt_det)));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      // R10: an enable bit only drops when its own channel detects
      p_enable_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(ch_enable[i]) |-> $past(ovl_det[i] || ovt_det[i]));

      // R2: no code appears without a detect in the sampling cycle
      p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (diag_code[2*i +: 2] == 2'b00 && !ovl_det[i] && !ovt_det[i])
            |=> (diag_code[2*i +: 2] == 2'b00));

      // R8: code 11 is never produced
      p_no_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
         diag_code[2*i +: 2] != 2'b11);
   end
endmodule

bind fault_guard fg_checker #(.NUM_CH(NUM_CH)) u_fg_checker (
   .clk(clk), .rst_n(rst_n), .ovl_det(ovl_det), .ovt_det(ovt_det),
   .diag_clr(diag_clr), .diag_code(diag_code), .fault_n(fault_n),
   .ch_enable(ch_enable)
);

// File: tb/tb_fault_guard.sv
`timescale 1ns/1ps
module tb_fault_guard;
   localparam int N = 8;
   localparam int F = 64;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   ovl_det = '0, ovt_det = '0;
   logic [N-1:0]   ovl_lm, ovt_lm;
   logic           diag_clr = 1'b0;
   logic [2*N-1:0] diag_code;
   logic           fault_n;
   logic [N-1:0]   ch_enable;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   // ch1 ovl limit, ch2 ovl latch, ch3 ovt auto, ch4 ovt latch,
   // ch5 both non-latching, ch6/ch7 ovl latch
   assign ovl_lm = 8'b1100_0100;
   assign ovt_lm = 8'b0001_0000;

   fault_guard #(.NUM_CH(N), .FILT_CYC(F)) dut (
      .clk(clk), .rst_n(rst_n), .ovl_det(ovl_det), .ovt_det(ovt_det),
      .ovl_latch_mode(ovl_lm), .ovt_latch_mode(ovt_lm),
      .diag_clr(diag_clr), .diag_code(diag_code), .fault_n(fault_n),
      .ch_enable(ch_enable)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic hold(input bit ovt, input int ch, input int n);
      @(negedge clk);
      if (ovt) ovt_det[ch] = 1'b1; else ovl_det[ch] = 1'b1;
      repeat (n) @(negedge clk);
   endtask

   task automatic drop_all();
      ovl_det = '0; ovt_det = '0;
      @(negedge clk);
   endtask

   task automatic clear();
      @(negedge clk); diag_clr = 1'b1;
      @(negedge clk); diag_clr = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 code", diag_code, 0);
      check("R1 flag", fault_n, 1);
      check("R1 enable", ch_enable, 8'hFF);
   endtask

   task automatic t_glitch();
      hold(0, 0, F - 1); drop_all();
      hold(1, 0, F - 1); drop_all();
      repeat (2) @(negedge clk);
      check("R2 code", diag_code, 0);
      check("R2 flag", fault_n, 1);
      check("R2 enable", ch_enable, 8'hFF);
   endtask

   task automatic t_ovl_limit();
      hold(0, 1, F);
      check("R3 code ovl", diag_code, 16'h0004);
      check("R3 flag", fault_n, 0);
      check("R4 enable", ch_enable, 8'hFF);
      drop_all(); clear();
      check("R9 code", diag_code, 0);
      check("R9 flag", fault_n, 1);
   endtask

   task automatic t_ovl_latch();
      hold(0, 2, F);
      check("R5 off", ch_enable, 8'hFB);
      drop_all(); repeat (3) @(negedge clk);
      check("R5 held", ch_enable, 8'hFB);
      clear();
      check("R5 release", ch_enable, 8'hFF);
      check("R5 code", diag_code, 0);
   endtask

   task automatic t_ovt_auto();
      hold(1, 3, F);
      check("R3 code ovt", diag_code, 16'h0080);
      check("R6 off", ch_enable, 8'hF7);
      drop_all();
      check("R6 restart", ch_enable, 8'hFF);
      check("R6 code kept", diag_code, 16'h0080);
      clear();
   endtask

   task automatic t_ovt_latch();
      hold(1, 4, F);
      check("R7 off", ch_enable, 8'hEF);
      drop_all(); repeat (3) @(negedge clk);
      check("R7 held", ch_enable, 8'hEF);
      clear();
      check("R7 release", ch_enable, 8'hFF);
   endtask

   task automatic t_overwrite();
      hold(0, 5, F); drop_all();
      check("R8 first", diag_code, 16'h0400);
      hold(1, 5, F); drop_all();
      check("R8 overwrite", diag_code, 16'h0800);
      clear();
      @(negedge clk); ovl_det[5] = 1'b1; ovt_det[5] = 1'b1;
      repeat (F) @(negedge clk);
      check("R8 priority", diag_code, 16'h0800);
      drop_all(); clear();
   endtask

   task automatic t_clear_persist();
      hold(0, 6, F);
      clear();
      check("R9 persist code", diag_code, 16'h1000);
      check("R9 persist lock", ch_enable, 8'hBF);
      drop_all(); clear();
      check("R9 final", ch_enable, 8'hFF);
      check("R9 final code", diag_code, 0);
   endtask

   task automatic t_independent();
      hold(0, 7, F);
      check("R10 code", diag_code, 16'h4000);
      check("R10 enable", ch_enable, 8'h7F);
      drop_all(); clear();
      check("R10 clear", ch_enable, 8'hFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_glitch();
      t_ovl_limit();
      t_ovl_latch();
      t_ovt_auto();
      t_ovt_latch();
      t_overwrite();
      t_clear_persist();
      t_independent();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule